// File: doc/BRIEF.md
# Opcode Substitution Bus Interposer

This block sits in the data path between a memory data bus and a processor's data bus. Its only view of the processor is the opcode-fetch strobe and the clock phase signal, and it samples both on a faster system clock. A read that is not an opcode fetch goes through unchanged, and so does an ordinary opcode fetch. An opcode fetch whose byte carries the reserved tag in its low three bits is different: the block cuts the direct path and drives a substitute opcode onto the processor bus. The substitute comes from a 32-entry constant table indexed by the upper five bits of the fetched byte. A substitute can be any legal opcode, so the processor's own addressing logic does part of the work of the new instruction.

On every opcode fetch the block also captures the original memory byte, never the substitute. It counts the clock-phase cycles since that fetch and raises a flag while the current instruction is an extended one. Downstream extension logic uses these three outputs to carry out the rest of the new instruction.

A delayed mode covers processors that latch the opcode too early for the substitution path. In this mode the reserved byte reaches the processor unchanged and runs as a one-cycle no-op. The substitute is then driven during the next opcode fetch, whatever that fetch reads from memory.

Top module: `opsub_interposer`

## Requirements
- R1: While the fetch strobe is low, the processor bus equals the memory bus for every byte value, including bytes whose low three bits are 3'b011.
- R2: In immediate mode (delayed-mode select low), while the fetch strobe is high and the memory byte's bits [2:0] equal 3'b011, the processor bus carries table entry i, where i is memory bits [7:4:3] read as bits [7:3]. Entry i equals {i, 3'b000} XOR 8'hEA.
- R3: While the fetch strobe is high, the byte's bits [2:0] differ from 3'b011 and no delayed substitute is pending, the processor bus equals the memory bus.
- R4: The latched opcode captures the raw memory byte once per fetch cycle, in the first system clock where both the clock phase and the fetch strobe are high. It does not change at any other time.
- R5: The cycle count becomes 0 on each opcode capture and then rises by 1 on every falling edge of the clock phase. It saturates at 7.
- R6: The extended flag becomes 1 on a capture whose byte has bits [2:0] = 3'b011 and becomes 0 on a capture of any other byte. Between captures it holds its value.
- R7: In delayed mode a reserved fetch passes through unchanged. During the next fetch cycle the processor bus carries that reserved byte's table entry instead of the memory byte, even when non-fetch cycles come in between. The fetch after that passes through normally.
- R8: A synchronous reset clears the latched opcode to 8'h00, the cycle count to 0 and the extended flag to 0, and cancels any pending delayed substitute.
- R9: A substitute driven onto the processor bus never has bits [2:0] equal to 3'b011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the processor signals |
| rst | input | 1 | Synchronous reset, active high |
| fetch_strb | input | 1 | Opcode-fetch strobe from the processor |
| phi2 | input | 1 | Processor clock phase; high during the data half of a bus cycle |
| delay_mode | input | 1 | 1 selects delayed substitution, 0 selects immediate substitution |
| mem_data | input | 8 | Byte on the memory data bus |
| cpu_data | output | 8 | Byte driven to the processor data bus |
| op_latched | output | 8 | Original opcode of the current instruction |
| cyc_count | output | 3 | Phase cycles since the last opcode fetch, saturating |
| ext_flag | output | 1 | Current instruction uses a reserved opcode |

## Verification
The bench sends reserved-tag bytes through non-fetch cycles. A design that decoded the tag without checking the strobe would corrupt operand and data reads. It compares the latched opcode with the raw byte, so a design that latched the multiplexer output shows the substitute instead. In delayed mode it puts non-fetch cycles between the reserved fetch and the next fetch, which catches a design that fires the substitute one cycle late or drops it on the next bus cycle. It also runs the cycle count past eight phase edges to catch wrap-around, and resets in the middle of a pending substitution to catch a design that leaves the substitute armed.

// File: rtl/opsub_pkg.sv
package opsub_pkg;
  localparam int OP_W  = 8;
  localparam int TAG_W = 3;
  localparam int IDX_W = OP_W - TAG_W;

  typedef logic [OP_W-1:0]  op_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [TAG_W-1:0] tag_t;

  // A byte is reserved when its low field equals the tag.
  function automatic logic is_reserved(input op_t b, input tag_t tag);
    return b[TAG_W-1:0] == tag;
  endfunction

  // Substitute opcode for table slot i.
  function automatic op_t sub_entry(input idx_t i, input op_t mask);
    return {i, {TAG_W{1'b0}}} ^ mask;
  endfunction

  function automatic idx_t upper_idx(input op_t b);
    return b[OP_W-1:TAG_W];
  endfunction
endpackage

// File: rtl/opsub_table.sv
module opsub_table
  import opsub_pkg::*;
#(
  parameter op_t SUB_MASK = 8'hEA
) (
  input  idx_t idx,
  output op_t  sub_op
);
  localparam int DEPTH = 1 << IDX_W;

  op_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = sub_entry(idx_t'(i), SUB_MASK);
  end

  assign sub_op = rom[idx];
endmodule

// File: rtl/opsub_tracker.sv
module opsub_tracker
  import opsub_pkg::*;
#(
  parameter tag_t RSV_TAG = 3'b011,
  parameter int   CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_strb,
  input  logic             phi2,
  input  op_t              mem_data,
  output logic             fetch_event,
  output logic             phi2_fall,
  output logic             fetch_seen,
  output op_t              op_latched,
  output logic [CNT_W-1:0] cyc_count,
  output logic             ext_flag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic phi2_q;
  logic seen_q;

  assign phi2_fall   = phi2_q & ~phi2;
  assign fetch_event = phi2 & fetch_strb & ~seen_q;
  assign fetch_seen  = seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q     <= 1'b0;
      seen_q     <= 1'b0;
      op_latched <= '0;
      cyc_count  <= '0;
      ext_flag   <= 1'b0;
    end else begin
      phi2_q <= phi2;
      if (phi2_fall)
        seen_q <= 1'b0;
      else if (fetch_event)
        seen_q <= 1'b1;

      if (fetch_event) begin
        op_latched <= mem_data;
        ext_flag   <= is_reserved(mem_data, RSV_TAG);
        cyc_count  <= '0;
      end else if (phi2_fall && cyc_count != CNT_MAX) begin
        cyc_count <= cyc_count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/opsub_mux.sv
module opsub_mux
  import opsub_pkg::*;
#(
  parameter tag_t RSV_TAG = 3'b011
) (
  input  logic clk,
  input  logic rst,
  input  logic fetch_strb,
  input  logic delay_mode,
  input  op_t  mem_data,
  input  op_t  sub_op,
  input  logic fetch_event,
  input  logic phi2_fall,
  input  logic fetch_seen,
  output op_t  cpu_data,
  output logic pend_active
);
  logic arm_q;
  logic pend_q;
  op_t  pend_op_q;
  logic rsv_now;

  assign rsv_now     = is_reserved(mem_data, RSV_TAG);
  assign pend_active = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q     <= 1'b0;
      pend_q    <= 1'b0;
      pend_op_q <= '0;
    end else begin
      if (fetch_event && delay_mode && rsv_now && !pend_q && !arm_q) begin
        arm_q     <= 1'b1;
        pend_op_q <= sub_op;
      end
      if (phi2_fall) begin
        if (arm_q) begin
          arm_q  <= 1'b0;
          pend_q <= 1'b1;
        end else if (pend_q && fetch_seen) begin
          pend_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    if (fetch_strb && pend_q)
      cpu_data = pend_op_q;
    else if (fetch_strb && !delay_mode && rsv_now)
      cpu_data = sub_op;
    else
      cpu_data = mem_data;
  end
endmodule

// File: rtl/opsub_interposer.sv
module opsub_interposer
  import opsub_pkg::*;
#(
  parameter tag_t RSV_TAG  = 3'b011,
  parameter op_t  SUB_MASK = 8'hEA,
  parameter int   CNT_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_strb,
  input  logic             phi2,
  input  logic             delay_mode,
  input  logic [7:0]       mem_data,
  output logic [7:0]       cpu_data,
  output logic [7:0]       op_latched,
  output logic [CNT_W-1:0] cyc_count,
  output logic             ext_flag
);
  logic fetch_event;
  logic phi2_fall;
  logic fetch_seen;
  logic pend_active;
  op_t  sub_op;

  opsub_table #(.SUB_MASK(SUB_MASK)) u_table (
    .idx    (upper_idx(mem_data)),
    .sub_op (sub_op)
  );

  opsub_tracker #(.RSV_TAG(RSV_TAG), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .fetch_strb  (fetch_strb),
    .phi2        (phi2),
    .mem_data    (mem_data),
    .fetch_event (fetch_event),
    .phi2_fall   (phi2_fall),
    .fetch_seen  (fetch_seen),
    .op_latched  (op_latched),
    .cyc_count   (cyc_count),
    .ext_flag    (ext_flag)
  );

  opsub_mux #(.RSV_TAG(RSV_TAG)) u_mux (
    .clk         (clk),
    .rst         (rst),
    .fetch_strb  (fetch_strb),
    .delay_mode  (delay_mode),
    .mem_data    (mem_data),
    .sub_op      (sub_op),
    .fetch_event (fetch_event),
    .phi2_fall   (phi2_fall),
    .fetch_seen  (fetch_seen),
    .cpu_data    (cpu_data),
    .pend_active (pend_active)
  );
endmodule

// File: rtl/opsub_checker.sv
module opsub_checker #(
  parameter logic [2:0] RSV_TAG = 3'b011,
  parameter int         CNT_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_strb,
  input logic             delay_mode,
  input logic [7:0]       mem_data,
  input logic [7:0]       cpu_data,
  input logic [7:0]       op_latched,
  input logic [CNT_W-1:0] cyc_count,
  input logic             ext_flag,
  input logic             fetch_event,
  input logic             phi2_fall,
  input logic             pend_active
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assert_passthru_R1: assert property (@(posedge clk) disable iff (rst)
    !fetch_strb |-> cpu_data == mem_data);

  // R2, R9: an immediate substitute never carries the reserved tag
  assert_subst_tag_R9: assert property (@(posedge clk) disable iff (rst)
    (fetch_strb && !delay_mode && !pend_active && mem_data[2:0] == RSV_TAG)
      |-> cpu_data[2:0] != RSV_TAG);

  assert_normal_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_strb && !pend_active && mem_data[2:0] != RSV_TAG) |-> cpu_data == mem_data);

  assert_latch_raw_R4: assert property (@(posedge clk) disable iff (rst)
    fetch_event |=> op_latched == $past(mem_data));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !fetch_event |=> $stable(op_latched));

  assert_count_clear_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_event |=> cyc_count == '0);

  assert_count_sat_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc_count == CNT_MAX && !fetch_event) |=> cyc_count == CNT_MAX);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (phi2_fall && !fetch_event && cyc_count != CNT_MAX) |=> cyc_count == $past(cyc_count) + 1'b1);

  assert_ext_flag_R6: assert property (@(posedge clk) disable iff (rst)
    fetch_event |=> ext_flag == ($past(mem_data[2:0]) == RSV_TAG));
endmodule

bind opsub_interposer opsub_checker #(.RSV_TAG(RSV_TAG), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_strb  (fetch_strb),
  .delay_mode  (delay_mode),
  .mem_data    (mem_data),
  .cpu_data    (cpu_data),
  .op_latched  (op_latched),
  .cyc_count   (cyc_count),
  .ext_flag    (ext_flag),
  .fetch_event (fetch_event),
  .phi2_fall   (phi2_fall),
  .pend_active (pend_active)
);

// File: tb/opsub_interposer_test.sv
`timescale 1ns/1ps
module opsub_interposer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fetch_strb = 1'b0;
  logic       phi2 = 1'b0;
  logic       delay_mode = 1'b0;
  logic [7:0] mem_data = 8'h00;
  logic [7:0] cpu_data;
  logic [7:0] op_latched;
  logic [2:0] cyc_count;
  logic       ext_flag;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  opsub_interposer uut (
    .clk(clk), .rst(rst), .fetch_strb(fetch_strb), .phi2(phi2),
    .delay_mode(delay_mode), .mem_data(mem_data), .cpu_data(cpu_data),
    .op_latched(op_latched), .cyc_count(cyc_count), .ext_flag(ext_flag)
  );

  // Independent restatement of the table rule: slot i -> {i,000} ^ 8'hEA
  function automatic logic [7:0] expect_sub(input logic [7:0] b);
    logic [7:0] hi;
    hi = b & 8'hF8;
    return hi ^ 8'hEA;
  endfunction

  // {fetch, data, expected cpu byte, expected ext after a fetch}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 8'hA9, 8'hA9, 1'b0},
    {1'b0, 8'h0B, 8'h0B, 1'b0},
    {1'b1, 8'h03, 8'hEA, 1'b1},
    {1'b0, 8'h33, 8'h33, 1'b1},
    {1'b1, 8'hFB, 8'h12, 1'b1},
    {1'b1, 8'h4C, 8'h4C, 1'b0},
    {1'b1, 8'h5B, 8'hB2, 1'b1},
    {1'b0, 8'hFB, 8'hFB, 1'b1},
    {1'b1, 8'h83, 8'h6A, 1'b1},
    {1'b1, 8'hEA, 8'hEA, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One processor bus cycle: two clocks with the phase low, then the phase high
  task automatic bus_cycle(input logic f, input logic [7:0] d, output logic [7:0] seen);
    @(negedge clk);
    phi2 = 1'b0; fetch_strb = f; mem_data = d;
    @(negedge clk);
    @(negedge clk);
    phi2 = 1'b1;
    #1 seen = cpu_data;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; phi2 = 1'b0; fetch_strb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] seen;
    logic [7:0] last_op;
    do_reset();
    #1;
    check("R8 reset opcode", op_latched, 8'h00);
    check("R8 reset count", {5'b0, cyc_count}, 8'h00);
    check("R8 reset ext", {7'b0, ext_flag}, 8'h00);

    // vector walk, immediate mode
    last_op = 8'h00;
    for (int k = 0; k < NV; k++) begin
      logic f;
      logic [7:0] d, ex;
      logic xe;
      {f, d, ex, xe} = VEC[k];
      bus_cycle(f, d, seen);
      if (!f) check("R1 non-fetch passthrough", seen, ex);
      else if (d[2:0] == 3'b011) begin
        check("R2 immediate substitute", seen, ex);
        check("R2 table rule", seen, expect_sub(d));
        check("R9 substitute tag", {5'b0, seen[2:0]} == 8'h03 ? 8'h01 : 8'h00, 8'h00);
      end else check("R3 normal fetch passthrough", seen, ex);
      if (f) last_op = d;
      check("R4 raw opcode latched", op_latched, last_op);
      check("R6 ext flag", {7'b0, ext_flag}, {7'b0, xe});
    end

    // cycle count and saturation
    bus_cycle(1'b1, 8'hAD, seen);
    check("R5 count after fetch", {5'b0, cyc_count}, 8'h00);
    for (int k = 1; k <= 9; k++) begin
      bus_cycle(1'b0, 8'h03, seen);
      check("R5 count step/saturate", {5'b0, cyc_count}, (k > 7) ? 8'h07 : 8'(k));
      check("R4 opcode holds on data reads", op_latched, 8'hAD);
    end
    bus_cycle(1'b1, 8'h60, seen);
    check("R5 count clears on fetch", {5'b0, cyc_count}, 8'h00);

    // delayed mode, back-to-back fetches
    delay_mode = 1'b1;
    bus_cycle(1'b1, 8'h0B, seen);
    check("R7 reserved passes in delayed mode", seen, 8'h0B);
    check("R7 ext set on reserved", {7'b0, ext_flag}, 8'h01);
    bus_cycle(1'b1, 8'hA9, seen);
    check("R7 substitute on next fetch", seen, expect_sub(8'h0B));
    check("R7 raw byte latched", op_latched, 8'hA9);
    bus_cycle(1'b1, 8'hA9, seen);
    check("R7 following fetch normal", seen, 8'hA9);

    // delayed mode with data cycles in between
    bus_cycle(1'b1, 8'hDB, seen);
    check("R7 reserved passes", seen, 8'hDB);
    bus_cycle(1'b0, 8'h55, seen);
    check("R7 data read untouched while pending", seen, 8'h55);
    bus_cycle(1'b0, 8'h13, seen);
    check("R7 reserved data read untouched", seen, 8'h13);
    bus_cycle(1'b1, 8'h20, seen);
    check("R7 substitute after data cycles", seen, expect_sub(8'hDB));
    bus_cycle(1'b1, 8'h20, seen);
    check("R7 pending consumed", seen, 8'h20);

    // reset mid-pending clears everything
    bus_cycle(1'b1, 8'h7B, seen);
    do_reset();
    #1;
    check("R8 reset opcode mid-run", op_latched, 8'h00);
    check("R8 reset ext mid-run", {7'b0, ext_flag}, 8'h00);
    bus_cycle(1'b1, 8'hA9, seen);
    check("R8 pending cancelled by reset", seen, 8'hA9);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule